// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block sits between a host bus and a network controller. It owns the 16-byte station-address store and decides what each bus access reaches. Each access arrives in a single cycle and carries a view select (I/O or memory-mapped), an offset, a size code, a write flag and write data. The block decodes these together with a word/dword I/O mode bit. A matching access is served from the address store, handed on to the controller's register window, or answered with an all-ones default.

Multi-byte reads are built from consecutive store bytes in little-endian order, and writes are split back into bytes in the same order. A write to the store has effect only while a write-enable control bit is set. Both control bits are loaded through a small control strobe and clear on reset. The register window is outside the block and is reached through a request/response port. That port returns read data one cycle after the request.

Top module: `prom_access_decoder`

## Requirements
- R1: After reset both control bits are clear and the store holds the parameter image: bytes 0..15 are 52 54 00 12 34 56, eight zero bytes, then 57 57.
- R2: A store write changes the store only while the write-enable bit is set. Otherwise it is ignored, and a later read returns the old byte.
- R3: In the I/O view (bus_mmio=0), offsets below 0x10 target the store. Offsets of 0x10 and above target the register window, which receives the full offset unchanged.
- R4: With the dword bit clear, the I/O view accepts store accesses of size code 0 (8-bit) at any offset, and of size code 1 (16-bit) only at even offsets.
- R5: With the dword bit set, the I/O view accepts only store accesses of size code 2 (32-bit) at offsets that are a multiple of 4.
- R6: A multi-byte store access is little-endian. The byte at the base offset is bits 7:0, and each following byte occupies the next 8 bits.
- R7: A read that matches no legal case returns all ones over its width: 0xFF for code 0, 0xFFFF for code 1, 0xFFFFFFFF for code 2 or 3. A write that matches no legal case is dropped.
- R8: The register window receives only size codes 1 and 2. In the I/O view, any other size at 0x10 or above is unmatched.
- R9: In the memory-mapped view (bus_mmio=1), address bit 4 clear selects the store and ignores the dword bit. A store access of any of the three sizes uses offset bits 3:0, and the bytes wrap modulo 16.
- R10: In the memory-mapped view with bit 4 set, an 8-bit access is dropped and reads 0xFF. 16-bit and 32-bit accesses go to the window with the offset masked to bits 3:0.
- R11: Each read request gives exactly one bus_rvalid pulse on the next cycle. For a window read, bus_rdata carries win_rdata unmodified from that cycle.
- R12: Address bits above bit 4 do not affect store indexing in the memory-mapped view, so offset 0x25 aliases offset 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Load strobe for both control bits |
| ctl_prom_we | input | 1 | New value of the store write-enable bit |
| ctl_dword | input | 1 | New value of the dword I/O mode bit |
| bus_req | input | 1 | Access valid this cycle |
| bus_mmio | input | 1 | 0 = I/O view, 1 = memory-mapped view |
| bus_addr | input | ADDR_W | Access offset |
| bus_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| bus_we | input | 1 | 1 = write |
| bus_wdata | input | 32 | Write data, little-endian lanes |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read response data |
| win_req | output | 1 | Register window request |
| win_we | output | 1 | Register window write flag |
| win_off | output | ADDR_W | Register window offset |
| win_size | output | 2 | Register window size code |
| win_wdata | output | 32 | Register window write data |
| win_rdata | input | 32 | Register window read data, valid the cycle after a read request |

## Verification
The hardest cases to reach are the ones where the same offset gives different results depending on state set by earlier traffic. Examples are a 32-bit read that only succeeds after the dword bit is loaded, and a write that only lands after the enable bit is loaded. The stimulus walks the control bits through off/on combinations and repeats one access under each. Each write is paired with a read-back through a view that is legal at that moment. The memory-mapped wrap case is reached by first writing the top store bytes with a 32-bit dword-mode write, then reading at offsets 0x0E and 0x0F so the result spans both ends of the store.

// File: rtl/pad_pkg.sv
package pad_pkg;
    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_X = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PROM = 2'd1,
        TGT_WIN  = 2'd2
    } tgt_e;

    localparam int unsigned STORE_BYTES = 16;
    localparam int unsigned LANES       = 4;
endpackage

// File: rtl/pad_decode.sv
module pad_decode
    import pad_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              mmio,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              dword,
    output tgt_e              tgt,
    output logic [2:0]        nbytes,
    output logic [3:0]        prom_off,
    output logic [ADDR_W-1:0] win_off
);
    localparam int unsigned HI_W = ADDR_W - 4;

    logic wide_ok;
    assign wide_ok = (size == SZ_H) || (size == SZ_W);

    always_comb begin
        tgt      = TGT_NONE;
        nbytes   = 3'd0;
        prom_off = addr[3:0];
        win_off  = addr;
        if (mmio) begin
            win_off = {{HI_W{1'b0}}, addr[3:0]};
            if (!addr[4]) begin
                case (size)
                    SZ_B:    begin tgt = TGT_PROM; nbytes = 3'd1; end
                    SZ_H:    begin tgt = TGT_PROM; nbytes = 3'd2; end
                    SZ_W:    begin tgt = TGT_PROM; nbytes = 3'd4; end
                    default: tgt = TGT_NONE;
                endcase
            end else if (wide_ok) begin
                tgt = TGT_WIN;
            end
        end else if (addr[ADDR_W-1:4] == '0) begin
            if (!dword) begin
                if (size == SZ_B) begin
                    tgt = TGT_PROM; nbytes = 3'd1;
                end else if (size == SZ_H && !addr[0]) begin
                    tgt = TGT_PROM; nbytes = 3'd2;
                end
            end else if (size == SZ_W && addr[1:0] == 2'b00) begin
                tgt = TGT_PROM; nbytes = 3'd4;
            end
        end else if (wide_ok) begin
            tgt = TGT_WIN;
        end
    end
endmodule

// File: rtl/pad_store.sv
module pad_store
    import pad_pkg::*;
#(
    parameter logic [8*STORE_BYTES-1:0] INIT = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [3:0]                 off,
    input  logic [2:0]                 nbytes,
    input  logic [8*LANES-1:0]         wdata,
    output logic [8*LANES-1:0]         rdata,
    output logic [8*STORE_BYTES-1:0]   image
);
    logic [STORE_BYTES-1:0][7:0] mem_d, mem_q;
    logic [LANES-1:0][3:0]       lane_idx;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_idx[g] = off + 4'(g);
        assign rdata[8*g +: 8] = (3'(g) < nbytes) ? mem_q[lane_idx[g]] : 8'h00;
    end

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < LANES; i++) begin
            if (wr && (3'(i) < nbytes)) begin
                mem_d[lane_idx[i]] = wdata[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= INIT;
        else        mem_q <= mem_d;
    end

    assign image = mem_q;
endmodule

// File: rtl/prom_access_decoder.sv
module prom_access_decoder
    import pad_pkg::*;
#(
    parameter int unsigned              ADDR_W    = 6,
    parameter logic [8*STORE_BYTES-1:0] PROM_INIT = 128'h5757_0000_0000_0000_0000_5634_1200_5452
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_prom_we,
    input  logic              ctl_dword,
    input  logic              bus_req,
    input  logic              bus_mmio,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic              win_req,
    output logic              win_we,
    output logic [ADDR_W-1:0] win_off,
    output logic [1:0]        win_size,
    output logic [31:0]       win_wdata,
    input  logic [31:0]       win_rdata
);
    typedef struct packed {
        logic        pwe;
        logic        dword;
        logic        rvalid;
        logic        sel_win;
        logic [31:0] rdata;
    } state_t;

    state_t st_d, st_q;

    tgt_e              tgt;
    logic [2:0]        nbytes;
    logic [3:0]        prom_off;
    logic [ADDR_W-1:0] dec_win_off;
    logic              prom_wr;
    logic [31:0]       prom_rdata;
    logic [127:0]      prom_image;
    logic              rd_req;

    pad_decode #(.ADDR_W(ADDR_W)) i_decode (
        .mmio     (bus_mmio),
        .addr     (bus_addr),
        .size     (bus_size),
        .dword    (st_q.dword),
        .tgt      (tgt),
        .nbytes   (nbytes),
        .prom_off (prom_off),
        .win_off  (dec_win_off)
    );

    assign prom_wr = bus_req && bus_we && (tgt == TGT_PROM) && st_q.pwe;
    assign rd_req  = bus_req && !bus_we;

    pad_store #(.INIT(PROM_INIT)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (prom_wr),
        .off    (prom_off),
        .nbytes (nbytes),
        .wdata  (bus_wdata),
        .rdata  (prom_rdata),
        .image  (prom_image)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rvalid  = rd_req;
        st_d.sel_win = 1'b0;
        if (ctl_wr) begin
            st_d.pwe   = ctl_prom_we;
            st_d.dword = ctl_dword;
        end
        if (rd_req) begin
            case (tgt)
                TGT_PROM: st_d.rdata = prom_rdata;
                TGT_WIN: begin
                    st_d.sel_win = 1'b1;
                    st_d.rdata   = 32'h0;
                end
                default: begin
                    case (bus_size)
                        SZ_B:    st_d.rdata = 32'h0000_00FF;
                        SZ_H:    st_d.rdata = 32'h0000_FFFF;
                        default: st_d.rdata = 32'hFFFF_FFFF;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_req    = bus_req && (tgt == TGT_WIN);
    assign win_we     = bus_we;
    assign win_off    = dec_win_off;
    assign win_size   = bus_size;
    assign win_wdata  = bus_wdata;
    assign bus_rvalid = st_q.rvalid;
    assign bus_rdata  = st_q.sel_win ? win_rdata : st_q.rdata;

    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));

    // R2
    prom_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pwe |=> $stable(prom_image));

    // R8
    win_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_req |-> (win_size == SZ_H || win_size == SZ_W));

    // R3
    io_win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && !bus_mmio) |-> (bus_addr >= ADDR_W'(16)));

    // R5
    dword_wr_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prom_wr && !bus_mmio && st_q.dword) |-> (bus_size == SZ_W && bus_addr[1:0] == 2'b00));

    // R7
    dword_byte_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !bus_mmio && st_q.dword && !ctl_wr && bus_size == SZ_B && bus_addr < ADDR_W'(16))
        |=> (bus_rdata == 32'h0000_00FF));

    // R10
    mmio_win_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_req && bus_mmio) |-> (win_off < ADDR_W'(16)));
endmodule

// File: tb/test_prom_access_decoder.sv
`timescale 1ns/1ps
module test_prom_access_decoder;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0, ctl_prom_we = 1'b0, ctl_dword = 1'b0;
    logic          bus_req = 1'b0, bus_mmio = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'd0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rvalid;
    logic [31:0]   bus_rdata;
    logic          win_req, win_we;
    logic [AW-1:0] win_off;
    logic [1:0]    win_size;
    logic [31:0]   win_wdata;
    logic [31:0]   win_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    prom_access_decoder #(.ADDR_W(AW)) i_prom_access_decoder (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_prom_we(ctl_prom_we), .ctl_dword(ctl_dword),
        .bus_req(bus_req), .bus_mmio(bus_mmio), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .win_req(win_req), .win_we(win_we), .win_off(win_off),
        .win_size(win_size), .win_wdata(win_wdata), .win_rdata(win_rdata)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] win_model(input logic [AW-1:0] off, input logic [1:0] sz);
        return {16'hC0DE, 2'b00, off, 6'b0, sz};
    endfunction

    // register window model: answers one cycle after a read request
    always @(posedge clk) begin
        if (win_req && !win_we) win_rdata <= win_model(win_off, win_size);
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each response
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rvalid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected response", bus_rdata, 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(bus_rdata === e, t, bus_rdata, e);
                end
            end
        end
    end

    task automatic ctl(input logic pwe, input logic dw);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_prom_we = pwe; ctl_dword = dw;
        @(posedge clk);
        #1 ctl_wr = 1'b0;
    endtask

    task automatic access(input logic mmio, input logic [AW-1:0] addr, input logic [1:0] sz,
                          input logic we, input logic [31:0] wd, input logic [31:0] exp,
                          input logic exp_win, input string tag);
        logic [AW-1:0] eoff;
        @(negedge clk);
        bus_req = 1'b1; bus_mmio = mmio; bus_addr = addr; bus_size = sz;
        bus_we = we; bus_wdata = wd;
        eoff = mmio ? {2'b00, addr[3:0]} : addr;
        #1;
        check(win_req === exp_win, {tag, " win_req"}, {31'b0, win_req}, {31'b0, exp_win});
        if (exp_win) begin
            check(win_off === eoff && win_size === sz && win_we === we,
                  {tag, " win fields"}, {16'b0, 2'b0, win_off, 6'b0, win_size}, {16'b0, 2'b0, eoff, 6'b0, sz});
            if (we) check(win_wdata === wd, {tag, " win wdata"}, win_wdata, wd);
        end
        if (!we) begin
            exp_q.push_back(exp_win ? win_model(eoff, sz) : exp);
            tag_q.push_back(tag);
        end
        @(posedge clk);
        #1 bus_req = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(bus_rvalid === 1'b0, "R1 rvalid after reset", {31'b0, bus_rvalid}, 32'h0);

        // R1 / R6 default image, word mode
        access(0, 6'h00, 2'd0, 0, 0, 32'h52,        0, "R1 io byte 0");
        access(0, 6'h02, 2'd1, 0, 0, 32'h1200,      0, "R6 io half 2");
        access(0, 6'h0E, 2'd0, 0, 0, 32'h57,        0, "R1 io byte 14");
        access(0, 6'h01, 2'd1, 0, 0, 32'hFFFF,      0, "R4 odd half");
        access(0, 6'h04, 2'd1, 0, 0, 32'h5634,      0, "R4 even half");
        access(0, 6'h00, 2'd2, 0, 0, 32'hFFFF_FFFF, 0, "R7 word mode dword read");

        // R2 write gating
        access(0, 6'h06, 2'd0, 1, 32'hAB, 0,        0, "R2 locked write");
        access(0, 6'h06, 2'd0, 0, 0, 32'h00,        0, "R2 locked readback");
        ctl(1'b1, 1'b0);
        access(0, 6'h06, 2'd0, 1, 32'hAB, 0,        0, "R2 open write");
        access(0, 6'h06, 2'd0, 0, 0, 32'hAB,        0, "R2 open readback");
        access(0, 6'h08, 2'd1, 1, 32'hBEEF, 0,      0, "R6 half write");
        access(0, 6'h08, 2'd0, 0, 0, 32'hEF,        0, "R6 low byte");
        access(0, 6'h09, 2'd0, 0, 0, 32'hBE,        0, "R6 high byte");
        access(0, 6'h03, 2'd1, 1, 32'h1111, 0,      0, "R7 odd half write");
        access(0, 6'h03, 2'd0, 0, 0, 32'h12,        0, "R7 odd half write dropped");

        // R5 dword mode
        ctl(1'b1, 1'b1);
        access(0, 6'h00, 2'd0, 0, 0, 32'hFF,        0, "R5 byte in dword mode");
        access(0, 6'h00, 2'd1, 0, 0, 32'hFFFF,      0, "R5 half in dword mode");
        access(0, 6'h02, 2'd2, 0, 0, 32'hFFFF_FFFF, 0, "R5 misaligned dword");
        access(0, 6'h08, 2'd2, 0, 0, 32'h0000_BEEF, 0, "R5 aligned dword");
        access(0, 6'h0C, 2'd2, 1, 32'h1122_3344, 0, 0, "R5 dword write");
        access(0, 6'h0C, 2'd2, 0, 0, 32'h1122_3344, 0, "R6 dword readback");
        access(0, 6'h00, 2'd0, 1, 32'h99, 0,        0, "R5 byte write dropped");
        access(0, 6'h00, 2'd2, 0, 0, 32'h1200_5452, 0, "R5 byte write dropped check");

        // R3 / R8 io window
        access(0, 6'h12, 2'd1, 0, 0, 0,             1, "R3 io window half read");
        access(0, 6'h12, 2'd0, 0, 0, 32'hFF,        0, "R8 io window byte read");
        access(0, 6'h14, 2'd2, 1, 32'hCAFE_F00D, 0, 1, "R3 io window dword write");
        access(0, 6'h10, 2'd3, 0, 0, 32'hFFFF_FFFF, 0, "R7 reserved size");

        // R9 / R10 / R12 memory-mapped view
        access(1, 6'h05, 2'd0, 0, 0, 32'h56,        0, "R9 mmio byte");
        access(1, 6'h0F, 2'd1, 0, 0, 32'h5211,      0, "R9 mmio half wrap");
        access(1, 6'h0E, 2'd2, 0, 0, 32'h5452_1122, 0, "R9 mmio dword wrap");
        access(1, 6'h25, 2'd0, 0, 0, 32'h56,        0, "R12 alias byte");
        access(1, 6'h33, 2'd1, 0, 0, 0,             1, "R10 mmio window half");
        access(1, 6'h1A, 2'd2, 1, 32'h0BAD_CAFE, 0, 1, "R10 mmio window write");
        access(1, 6'h13, 2'd0, 0, 0, 32'hFF,        0, "R10 mmio window byte read");
        access(1, 6'h13, 2'd0, 1, 32'h5A, 0,        0, "R10 mmio window byte write");
        access(1, 6'h21, 2'd0, 1, 32'h77, 0,        0, "R12 alias write");
        access(1, 6'h01, 2'd0, 0, 0, 32'h77,        0, "R12 alias readback");

        ctl(1'b0, 1'b0);
        access(1, 6'h00, 2'd2, 1, 32'hDEAD_BEEF, 0, 0, "R2 mmio locked write");
        access(1, 6'h00, 2'd2, 0, 0, 32'h1200_7752, 0, "R2 mmio locked readback");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R11 missing responses", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule